// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the bus-facing front end of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit data bus and separate read and write strobes. Addresses 0 to 2 reach the 16-bit count registers of channels 0 to 2. Address 3 is the control port. A byte written there either reconfigures one channel or asks that channel to freeze a snapshot of its running count.

Each channel moves 16-bit values over the 8-bit bus one byte at a time. The byte order follows the access type set by the last control word: low byte only, high byte only, or low byte then high byte. A completed count write produces a one-cycle load strobe and the assembled 16-bit value for the counting logic. A reconfiguration produces a one-cycle control pulse. The counters live outside this block. They supply their running values on `cnt_live`, which the block either reads through directly or captures on a latch command.

Top module: `timer_host_if`

## Requirements
- R1: A count write to address n (n = 0..2) affects channel n only. The load strobes and load values of the other channels do not change.
- R2: A control word is laid out as follows. Bits 7:6 hold the channel number. Bits 5:4 hold the access type: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 hold the mode, where codes 6 and 7 are stored as 2 and 3. Bit 0 holds the BCD flag. After reset every channel has mode 0, BCD 0 and access type low-then-high.
- R3: A control word with a non-latch access type updates the channel's mode, BCD flag and access type. One cycle after the write it raises that channel's `ctrl_wr` bit for one cycle. It also returns both byte pointers to the low byte and discards any pending latched value.
- R4: In low-only access, a data byte b loads {8'h00, b}. In high-only access it loads {b, 8'h00}. In both cases `load_stb` pulses for one cycle, one cycle after the write.
- R5: In low-then-high access, the first byte is held as the low half and produces no strobe. The second byte completes the value {second, first} and pulses `load_stb` one cycle after it is written.
- R6: A latch command (access bits 00) captures `cnt_live` of the selected channel on the clock edge of the write. Later reads of that channel return the captured bytes in the order set by the access type, low byte first in low-then-high access.
- R7: A latched value stays pending until all of its bytes have been read: two reads in low-then-high access, one read otherwise. A latch command issued while a value is pending is ignored.
- R8: When no latched value is pending, a read returns the live count byte picked by the access type. In low-then-high access, successive reads alternate low, high, low.
- R9: A read never produces a load strobe or a control pulse and never changes the mode or BCD outputs.
- R10: A control word whose channel field is 11 is ignored. It produces no pulse and changes no mode, BCD flag or pointer.
- R11: `rdata` is combinational during the read cycle. It is 0 when `rd_en` is low and 0 when address 3 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address (0..2 count, 3 control) |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read cycle |
| cnt_live | input | 48 | Running counts of the channels, 16 bits each, channel 0 lowest |
| chan_mode | output | 9 | Mode of each channel, 3 bits each |
| chan_bcd | output | 3 | BCD flag of each channel |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Assembled count per channel, 16 bits each |
| ctrl_wr | output | 3 | One-cycle pulse per channel on reconfiguration |

## Verification
The assertions assume that the host never asserts `wr_en` and `rd_en` in the same cycle. One of them checks this assumption, and every bench task drives exactly one strobe and drops it after the edge. They also assume that `cnt_live` does not change within the cycle of a latch command. The bench changes the live counts only between bus operations. Latch-order checks always start from a fresh control word, so the read pointer starts at the low byte.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       bcd;
        acc_e       acc;
    } chan_cfg_t;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    localparam chan_cfg_t CFG_RESET = '{mode: 3'd0, bcd: 1'b0, acc: ACC_BOTH};

    // Codes 6 and 7 alias the two periodic modes 2 and 3.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/timer_ctl_decode.sv
module timer_ctl_decode
    import timer_host_pkg::*;
(
    input  logic [BYTE_W-1:0] ctl_byte,
    output ctl_word_t         ctl
);
    always_comb begin
        ctl.sel  = ctl_byte[7:6];
        ctl.acc  = acc_e'(ctl_byte[5:4]);
        ctl.mode = fold_mode(ctl_byte[3:1]);
        ctl.bcd  = ctl_byte[0];
    end
endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
    import timer_host_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  ctl_word_t         ctl,
    input  logic              cnt_wr_en,
    input  logic              cnt_rd_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    output chan_cfg_t         cfg,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              ctrl_pulse,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam logic [1:0] CH_ID = 2'(CH);

    logic              wr_ptr;
    logic              rd_ptr;
    logic [1:0]        lat_left;
    logic [CNT_W-1:0]  lat_val;
    logic [BYTE_W-1:0] lo_hold;
    logic              sel_me, cmd_cfg, cmd_latch;
    logic [CNT_W-1:0]  rd_src;

    assign sel_me    = ctl_wr_en && (ctl.sel == CH_ID);
    assign cmd_cfg   = sel_me && (ctl.acc != ACC_LATCH);
    assign cmd_latch = sel_me && (ctl.acc == ACC_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= CFG_RESET;
            wr_ptr     <= 1'b0;
            rd_ptr     <= 1'b0;
            lat_left   <= 2'd0;
            lat_val    <= '0;
            lo_hold    <= '0;
            load_stb   <= 1'b0;
            load_val   <= '0;
            ctrl_pulse <= 1'b0;
        end else begin
            load_stb   <= 1'b0;
            ctrl_pulse <= 1'b0;
            if (cmd_cfg) begin
                cfg.mode   <= ctl.mode;
                cfg.bcd    <= ctl.bcd;
                cfg.acc    <= ctl.acc;
                wr_ptr     <= 1'b0;
                rd_ptr     <= 1'b0;
                lat_left   <= 2'd0;
                ctrl_pulse <= 1'b1;
            end else begin
                if (cmd_latch && lat_left == 2'd0) begin
                    lat_val  <= cnt_live;
                    lat_left <= (cfg.acc == ACC_BOTH) ? 2'd2 : 2'd1;
                end
                if (cnt_wr_en) begin
                    unique case (cfg.acc)
                        ACC_LO: begin
                            load_val <= {{BYTE_W{1'b0}}, wdata};
                            load_stb <= 1'b1;
                        end
                        ACC_HI: begin
                            load_val <= {wdata, {BYTE_W{1'b0}}};
                            load_stb <= 1'b1;
                        end
                        ACC_BOTH: begin
                            if (!wr_ptr) begin
                                lo_hold <= wdata;
                                wr_ptr  <= 1'b1;
                            end else begin
                                load_val <= {wdata, lo_hold};
                                load_stb <= 1'b1;
                                wr_ptr   <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (cnt_rd_en) begin
                    if (cfg.acc == ACC_BOTH) rd_ptr <= ~rd_ptr;
                    if (lat_left != 2'd0) lat_left <= lat_left - 2'd1;
                end
            end
        end
    end

    always_comb begin
        rd_src = (lat_left != 2'd0) ? lat_val : cnt_live;
        unique case (cfg.acc)
            ACC_HI:   rd_byte = rd_src[CNT_W-1:BYTE_W];
            ACC_BOTH: rd_byte = rd_ptr ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
            default:  rd_byte = rd_src[BYTE_W-1:0];
        endcase
    end

    assert_load_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> $past(cnt_wr_en));

    assert_ctrl_pulse_source_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_pulse |-> $past(ctl_wr_en && ctl.sel == CH_ID && ctl.acc != ACC_LATCH));

    assert_half_written_only_both_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ptr |-> cfg.acc == ACC_BOTH);

    assert_latch_held_R7: assert property (@(posedge clk) disable iff (rst)
        (lat_left != 2'd0 && $past(lat_left != 2'd0)) |-> $stable(lat_val));

    assert_latch_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        lat_left <= 2'd2);

    assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_rd_en) |-> (!load_stb && !ctrl_pulse && $stable(cfg)));

endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
    import timer_host_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [NCH*16-1:0]    cnt_live,
    output logic [NCH*3-1:0]     chan_mode,
    output logic [NCH-1:0]       chan_bcd,
    output logic [NCH-1:0]       load_stb,
    output logic [NCH*16-1:0]    load_val,
    output logic [NCH-1:0]       ctrl_wr
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    ctl_word_t         ctl;
    logic              ctl_wr_en;
    logic [BYTE_W-1:0] rd_bytes [NCH];

    assign ctl_wr_en = wr_en && (addr == CTRL_ADDR);

    timer_ctl_decode u_dec (
        .ctl_byte (wdata),
        .ctl      (ctl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg;
        timer_chan_regs #(.CH(c)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .ctl_wr_en  (ctl_wr_en),
            .ctl        (ctl),
            .cnt_wr_en  (wr_en && addr == 2'(c)),
            .cnt_rd_en  (rd_en && addr == 2'(c)),
            .wdata      (wdata),
            .cnt_live   (cnt_live[c*CNT_W +: CNT_W]),
            .cfg        (cfg),
            .load_stb   (load_stb[c]),
            .load_val   (load_val[c*CNT_W +: CNT_W]),
            .ctrl_pulse (ctrl_wr[c]),
            .rd_byte    (rd_bytes[c])
        );
        assign chan_mode[c*3 +: 3] = cfg.mode;
        assign chan_bcd[c]         = cfg.bcd;
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_en && addr == 2'(c)) rdata = rd_bytes[c];
    end

    assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

    assert_bad_select_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR && wdata[7:6] == 2'b11) |=> ctrl_wr == '0);

    assert_pulse_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb | ctrl_wr));

    assert_ctrl_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CTRL_ADDR) |-> rdata == 8'h00);

endmodule

// File: tb/timer_host_if_bench.sv
module timer_host_if_bench;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        addr;
    logic              wr_en, rd_en;
    logic [7:0]        wdata, rdata;
    logic [NCH*16-1:0] cnt_live;
    logic [NCH*3-1:0]  chan_mode;
    logic [NCH-1:0]    chan_bcd, load_stb, ctrl_wr;
    logic [NCH*16-1:0] load_val;

    int total = 0, bad = 0;
    bit done = 0;

    logic [NCH-1:0]    s_stb, s_ctl;
    logic [NCH*16-1:0] s_val;

    always #10 clk = ~clk;

    timer_host_if #(.NCH(NCH)) u_timer_host_if (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cnt_live(cnt_live), .chan_mode(chan_mode),
        .chan_bcd(chan_bcd), .load_stb(load_stb), .load_val(load_val), .ctrl_wr(ctrl_wr)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        s_stb = load_stb; s_val = load_val; s_ctl = ctrl_wr;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        s_stb = load_stb; s_ctl = ctrl_wr;
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] cw(input int ch, input int acc, input int m, input int b);
        return {2'(ch), 2'(acc), 3'(m), 1'(b)};
    endfunction

    function automatic logic [2:0] fold(input int m);
        return (m > 5) ? 3'(m - 4) : 3'(m);
    endfunction

    function automatic logic [15:0] live_of(input int ch, input logic [15:0] base);
        return base + 16'(ch) * 16'h1111;
    endfunction

    task automatic set_live(input logic [15:0] base);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) cnt_live[c*16 +: 16] = live_of(c, base);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        logic [15:0] v, old;
        logic [NCH*3-1:0] m_before;
        logic [NCH-1:0]   b_before;
        rst = 1'b1; addr = 0; wr_en = 0; rd_en = 0; wdata = 0; cnt_live = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R2 / R11: reset state
        chk(chan_mode == '0 && chan_bcd == '0, "R2 reset cfg", {chan_mode, chan_bcd}, 0);
        chk(load_stb == '0 && ctrl_wr == '0, "R3 reset pulses", {load_stb, ctrl_wr}, 0);
        chk(rdata == 8'h00, "R11 idle rdata", rdata, 0);

        // R2 / R3: control-word sweep
        for (int ch = 0; ch < NCH; ch++)
            for (int m = 0; m < 8; m++) begin
                wr(2'd3, cw(ch, 3, m, m & 1));
                chk(s_ctl == 3'(1 << ch), "R3 ctrl pulse", s_ctl, 48'(1 << ch));
                chk(chan_mode[ch*3 +: 3] == fold(m), "R2 mode decode", chan_mode[ch*3 +: 3], fold(m));
                chk(chan_bcd[ch] == 1'(m & 1), "R2 bcd decode", chan_bcd[ch], m & 1);
                @(posedge clk); #1;
                chk(ctrl_wr == '0, "R3 pulse one cycle", ctrl_wr, 0);
            end

        // R4 / R1: single-byte access
        for (int ch = 0; ch < NCH; ch++)
            for (int acc = 1; acc <= 2; acc++) begin
                wr(2'd3, cw(ch, acc, 2, 0));
                foreach (d2[i]) ;
                for (int k = 0; k < 4; k++) begin
                    d = 8'(k * 8'h55 + 8'h0F);
                    wr(2'(ch), d);
                    v = (acc == 1) ? {8'h00, d} : {d, 8'h00};
                    chk(s_stb == 3'(1 << ch), "R1 strobe channel", s_stb, 48'(1 << ch));
                    chk(s_val[ch*16 +: 16] == v, "R4 single-byte load", s_val[ch*16 +: 16], v);
                end
            end

        // R5: two-byte access
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2'd3, cw(ch, 3, 0, 0));
            for (int k = 0; k < 4; k++) begin
                v = 16'(k * 16'h3C5A + 16'h0102);
                wr(2'(ch), v[7:0]);
                chk(s_stb == '0, "R5 no strobe after low", s_stb, 0);
                wr(2'(ch), v[15:8]);
                chk(s_stb == 3'(1 << ch), "R5 strobe after high", s_stb, 48'(1 << ch));
                chk(s_val[ch*16 +: 16] == v, "R5 assembled value", s_val[ch*16 +: 16], v);
            end
        end

        // R3: control word resets write pointer
        wr(2'd0, 8'hAA);
        wr(2'd3, cw(0, 3, 0, 0));
        wr(2'd0, 8'h34);
        chk(s_stb == '0, "R3 pointer reset (no strobe)", s_stb, 0);
        wr(2'd0, 8'h12);
        chk(s_val[15:0] == 16'h1234, "R3 pointer reset value", s_val[15:0], 16'h1234);

        // R8: live reads
        set_live(16'hA1B2);
        for (int ch = 0; ch < NCH; ch++) begin
            v = live_of(ch, 16'hA1B2);
            wr(2'd3, cw(ch, 3, 2, 0));
            rd(2'(ch), d);  chk(d == v[7:0],  "R8 live low", d, v[7:0]);
            rd(2'(ch), d);  chk(d == v[15:8], "R8 live high", d, v[15:8]);
            rd(2'(ch), d);  chk(d == v[7:0],  "R8 alternation", d, v[7:0]);
            wr(2'd3, cw(ch, 1, 2, 0));
            rd(2'(ch), d);  chk(d == v[7:0],  "R8 low-only", d, v[7:0]);
            rd(2'(ch), d);  chk(d == v[7:0],  "R8 low-only repeat", d, v[7:0]);
            wr(2'd3, cw(ch, 2, 2, 0));
            rd(2'(ch), d);  chk(d == v[15:8], "R8 high-only", d, v[15:8]);
        end

        // R6 / R7 / R9: latch in two-byte access
        for (int ch = 0; ch < NCH; ch++) begin
            set_live(16'h4321);
            old = live_of(ch, 16'h4321);
            wr(2'd3, cw(ch, 3, 3, 1));
            m_before = chan_mode; b_before = chan_bcd;
            wr(2'd3, cw(ch, 0, 0, 0));
            set_live(16'h9876);
            wr(2'd3, cw(ch, 0, 0, 0));   // R7: ignored while pending
            rd(2'(ch), d);
            chk(d == old[7:0], "R6 latched low", d, old[7:0]);
            chk(s_stb == '0 && s_ctl == '0, "R9 read no pulse", {s_stb, s_ctl}, 0);
            rd(2'(ch), d);
            chk(d == old[15:8], "R7 latched high held", d, old[15:8]);
            chk(chan_mode == m_before && chan_bcd == b_before, "R9 cfg unchanged", chan_mode, m_before);
            v = live_of(ch, 16'h9876);
            rd(2'(ch), d);
            chk(d == v[7:0], "R7 released to live", d, v[7:0]);
        end

        // R6 / R7: latch in low-only access
        set_live(16'h0F0E);
        wr(2'd3, cw(1, 1, 0, 0));
        wr(2'd3, cw(1, 0, 0, 0));
        set_live(16'h5555);
        rd(2'd1, d);
        v = live_of(1, 16'h0F0E);
        chk(d == v[7:0], "R6 latched low-only", d, v[7:0]);
        rd(2'd1, d);
        v = live_of(1, 16'h5555);
        chk(d == v[7:0], "R7 single read releases", d, v[7:0]);

        // R3: control word drops pending latch
        wr(2'd3, cw(2, 3, 0, 0));
        wr(2'd3, cw(2, 0, 0, 0));
        set_live(16'h2468);
        wr(2'd3, cw(2, 3, 0, 0));
        rd(2'd2, d);
        v = live_of(2, 16'h2468);
        chk(d == v[7:0], "R3 latch discarded", d, v[7:0]);

        // R10: channel field 11 ignored
        m_before = chan_mode; b_before = chan_bcd;
        wr(2'd3, 8'hFF);
        chk(s_ctl == '0, "R10 no pulse", s_ctl, 0);
        chk(chan_mode == m_before && chan_bcd == b_before, "R10 cfg unchanged", chan_mode, m_before);

        // R11: control address reads zero
        rd(2'd3, d);
        chk(d == 8'h00, "R11 ctrl read", d, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule